// File: doc/BRIEF.md
# Programmable-Interval Watchdog Timer

This block is a watchdog that raises a reset request when software fails to service it in time. Software controls it through a single write-only control byte. That byte carries three things: an enable, a self-clearing restart strobe and a 3-bit interval code. A prescaler divides the system clock into a base tick of `PRESCALE` cycles. With a 12 MHz clock and the default of 3,000,000, one tick is a quarter second.

A tick counter compares elapsed ticks against the interval chosen by the code. Codes 1 to 7 select that many ticks, and code 0 selects eight ticks. When the interval runs out while the watchdog is enabled, the block pulses `wdt_rst_req` for one cycle and begins a new interval. The CPU reset logic that consumes the pulse sits outside this block.

Top module: `wdt_timer`

## Requirements
- R1: After `rst`, the watchdog is disabled with interval code 0. `wdt_rst_req` stays low until software enables it.
- R2: A control write (`cfg_we` high at a rising edge) takes its fields from `cfg_wdata`: bit 7 is enable, bit 6 is clear, bits 2:0 are the interval code. Bits 5:3 have no effect.
- R3: Elapsed time is counted in whole ticks of `PRESCALE` clock cycles. Two ticks are never adjacent.
- R4: Suppose a write enables the watchdog with clear set and code N in 1..7, and that write is sampled at edge 0. Then `wdt_rst_req` is high during the cycle that follows edge N*PRESCALE.
- R5: Code 0 selects an interval of 8 ticks (8*PRESCALE cycles).
- R6: Each timeout gives a request exactly one cycle wide. Counting then restarts from zero, so an unserviced watchdog requests once every interval.
- R7: A write with the clear bit set resets the prescaler and the tick counter at that edge. No request follows in the next cycle, and the next timeout is measured from that write.
- R8: While disabled, the block counts nothing and never requests. A write with enable 0 discards any progress, including when its clear bit is set. Re-enabling without clear starts from zero.
- R9: A write that keeps enable at 1 with clear at 0 does not restart the count. A new code applies from the next tick. If the ticks already elapsed reach the new interval, the request comes at that next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| wdt_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
On every cycle, the embedded assertions check the following: the request lasts a single cycle, it never follows a disabled state or a clear write, ticks are never adjacent, and both counters stay within range. The exact position of the request in time can only be shown by the bench's scenarios. That covers each interval code, the restart after a clear, progress kept across a write without clear, and an interval shortened mid-count. The bench compares all of these against a behavioural elapsed-cycle model on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CFG_W   = 8;
    localparam int CODE_W  = 3;
    localparam int TICK_W  = 4;
    localparam int EN_POS  = 7;
    localparam int CLR_POS = 6;

    typedef struct packed {
        logic              enable;
        logic              clear;
        logic [CODE_W-1:0] code;
    } wdt_cmd_t;

    function automatic wdt_cmd_t decode_cmd(input logic [CFG_W-1:0] d);
        wdt_cmd_t c;
        c.enable = d[EN_POS];
        c.clear  = d[CLR_POS];
        c.code   = d[CODE_W-1:0];
        return c;
    endfunction

    // code 0 selects the longest interval, eight ticks
    function automatic logic [TICK_W-1:0] interval_ticks(input logic [CODE_W-1:0] c);
        return (c == '0) ? TICK_W'(8) : TICK_W'(c);
    endfunction

endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              en_q,
    output logic [CODE_W-1:0] code_q,
    output logic              restart
);
    wdt_cmd_t cmd;
    logic     unused_cfg_bits;

    assign cmd             = decode_cmd(cfg_wdata);
    assign unused_cfg_bits = ^cfg_wdata[CLR_POS-1:CODE_W];
    // clearing or disabling both drop all progress
    assign restart         = cfg_we && (cmd.clear || !cmd.enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            code_q <= '0;
        end else if (cfg_we) begin
            en_q   <= cmd.enable;
            code_q <= cmd.code;
        end
    end

    AST_WRITE_TAKES_ENABLE: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (en_q == $past(cfg_wdata[EN_POS]))); // R2

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRESCALE = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0] pre_cnt;

    assign tick = en && (pre_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_cnt <= '0;
        end else if (en) begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
        end
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= LAST); // R3
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              req
);
    logic [TICK_W-1:0] ticks;
    logic [TICK_W-1:0] next_ticks;
    logic              expired;

    assign next_ticks = ticks + 1'b1;
    // >= so a shortened interval still fires at the next tick
    assign expired    = next_ticks >= interval_ticks(code);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ticks <= '0;
            req   <= 1'b0;
        end else begin
            req <= 1'b0;
            if (tick) begin
                if (expired) begin
                    ticks <= '0;
                    req   <= 1'b1;
                end else begin
                    ticks <= next_ticks;
                end
            end
        end
    end

    AST_TICKS_BELOW_EIGHT: assert property (@(posedge clk) disable iff (rst)
        ticks < TICK_W'(8)); // R5
    AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(tick)); // R3

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int PRESCALE = 3_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             wdt_rst_req
);
    logic              en_q;
    logic [CODE_W-1:0] code_q;
    logic              restart;
    logic              tick;

    wdt_ctrl_reg i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .en_q      (en_q),
        .code_q    (code_q),
        .restart   (restart)
    );

    wdt_prescaler #(.PRESCALE(PRESCALE)) i_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (en_q),
        .restart (restart),
        .tick    (tick)
    );

    wdt_tick_counter i_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (restart),
        .code    (code_q),
        .req     (wdt_rst_req)
    );

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_req |=> !wdt_rst_req); // R6
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !wdt_rst_req); // R8
    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[CLR_POS]) |=> !wdt_rst_req); // R7

endmodule

// File: tb/test_wdt_timer.sv
`timescale 1ns/1ps
module test_wdt_timer;
    localparam int P = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       wdt_rst_req;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural model: elapsed cycles since last restart
    bit m_en;
    int m_code;
    int m_el;
    bit m_req;

    always #4 clk = ~clk;

    wdt_timer #(.PRESCALE(P)) i_wdt_timer (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .wdt_rst_req(wdt_rst_req)
    );

    function automatic int limit(int c);
        return (c == 0) ? 8 : c;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_code = 0; m_el = 0; m_req = 0;
        end else begin
            m_req = 0;
            if (m_en) begin
                m_el++;
                if ((m_el % P) == 0 && (m_el / P) >= limit(m_code)) begin
                    m_req = 1; m_el = 0;
                end
            end
            if (cfg_we) begin
                if (cfg_wdata[6] || !cfg_wdata[7]) begin
                    m_el = 0; m_req = 0;
                end
                m_en = cfg_wdata[7];
                m_code = int'(cfg_wdata[2:0]);
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) check(wdt_rst_req == m_req, cur_req, wdt_rst_req, m_req);
        if (cycles > 100000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic wr(logic [7:0] d);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic first_pulse(int maxc, output int idx, output int cnt);
        idx = 0; cnt = 0;
        for (int k = 1; k <= maxc; k++) begin
            @(negedge clk);
            if (wdt_rst_req) begin
                cnt++;
                if (idx == 0) idx = k;
            end
        end
    endtask

    initial begin
        int idx, cnt;
        wait_cyc(3);
        rst = 1'b0;
        // R1: idle after reset
        check(wdt_rst_req == 1'b0, "R1", wdt_rst_req, 0);
        first_pulse(250, idx, cnt);
        check(cnt == 0, "R1", cnt, 0);

        // R4 and R6: code 3, periodic single pulses
        cur_req = "R6";
        wr(8'hC3);
        first_pulse(200, idx, cnt);
        check(idx == 3 * P, "R4", idx, 3 * P);
        check(cnt == 3, "R6", cnt, 3);

        // R4: every non-zero code
        cur_req = "R4";
        for (int c = 1; c < 8; c++) begin
            wr(8'hC0 | 8'(c));
            first_pulse(c * P, idx, cnt);
            check(idx == c * P, "R4", idx, c * P);
        end
        // R5: code 0 is eight ticks
        cur_req = "R5";
        wr(8'hC0);
        first_pulse(8 * P, idx, cnt);
        check(idx == 8 * P, "R5", idx, 8 * P);

        // R2: bits 5:3 ignored, clear not set, from disabled
        cur_req = "R2";
        wr(8'h00);
        wr(8'hBA);
        first_pulse(2 * P, idx, cnt);
        check(idx == 2 * P, "R2", idx, 2 * P);

        // R7: clear restarts count mid-interval
        cur_req = "R7";
        wr(8'hC2);
        wait_cyc(29);
        wr(8'hC2);
        first_pulse(2 * P, idx, cnt);
        check(idx == 2 * P, "R7", idx, 2 * P);
        check(cnt == 1, "R7", cnt, 1);

        // R8: disabled counts nothing; clear while disabled changes nothing
        cur_req = "R8";
        wr(8'hC1);
        wait_cyc(10);
        wr(8'h00);
        first_pulse(300, idx, cnt);
        check(cnt == 0, "R8", cnt, 0);
        wr(8'h41);
        first_pulse(100, idx, cnt);
        check(cnt == 0, "R8", cnt, 0);
        wr(8'h81);
        first_pulse(P, idx, cnt);
        check(idx == P, "R8", idx, P);

        // R9: write without clear keeps progress
        cur_req = "R9";
        wr(8'hC4);
        wait_cyc(49);
        wr(8'h84);
        first_pulse(30, idx, cnt);
        check(idx == 30, "R9", idx, 30);
        // R9: shorten interval below elapsed ticks
        wr(8'hC5);
        wait_cyc(69);
        wr(8'h82);
        first_pulse(20, idx, cnt);
        check(idx == 10, "R9", idx, 10);

        // R3: tick granularity, progress inside a tick lost on clear
        cur_req = "R3";
        wr(8'hC1);
        wait_cyc(P - 2);
        wr(8'hC1);
        first_pulse(P, idx, cnt);
        check(idx == P, "R3", idx, P);

        wr(8'h00);
        wait_cyc(5);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule